// File: doc/BRIEF.md
# Page-Buffered Self-Timed Write Engine

This block sits behind a two-wire serial memory interface. It gathers the data bytes of one write transfer in a small page buffer and copies them into a 2048 x 8 storage array only when the transfer is closed with STOP. The bus front end passes it the following events:

- a transfer-start strobe carrying the 11-bit start address;
- a data byte with a valid strobe;
- a STOP strobe;
- an abort strobe, raised when a repeated START arrives before STOP.

Once STOP commits a non-empty buffer, the engine raises `busy` for a fixed number of system clock cycles. During that time every bus-side input is ignored. A separate read port gives registered access to the array at any time.

The address is split into a 7-bit row, bits [10:4], and a 4-bit slot, bits [3:0]. Successive bytes advance only the slot, which wraps from 15 back to 0 inside the same row. A per-slot valid mask records which slots were loaded, so a partial page writes only those bytes. Each write simply overwrites the old contents. When the protect input is high the engine still accepts data bytes but throws them away, so nothing reaches the array.

Top module: `page_write_engine`

## Requirements
- R1: After reset `busy` is low.
- R2: The first data byte lands at the start address. Each further byte goes to the next slot: bits [3:0] increment modulo 16 and bits [10:4] stay fixed.
- R3: A transfer of 1 to 16 bytes writes exactly the slots it loaded. The other bytes of that 16-byte row keep their previous values.
- R4: With more than 16 bytes in one transfer, the slot pointer wraps. Each slot commits the last byte written to it.
- R5: The array is not changed before STOP. A read of a target address during the transfer returns the old value.
- R6: A STOP after at least one accepted byte makes `busy` high from the next clock edge. It stays high for exactly max(WR_CYCLES, 16) cycles.
- R7: While `busy` is high, start, data, STOP and abort inputs have no effect. They neither change the array nor lengthen or restart the busy interval.
- R8: A byte accepted while `wp` is high is discarded. If every byte of a transfer was discarded, STOP leaves `busy` low and the array unchanged.
- R9: A STOP with no data byte after the start leaves `busy` low.
- R10: An abort before STOP drops the buffered bytes. `busy` stays low, the array is unchanged, and a later STOP is ignored.
- R11: `rd_data` shows the array byte at `rd_addr` one clock edge after `rd_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | Start of a write transfer; loads `xfer_addr` |
| xfer_addr | input | 11 | Start address: row in [10:4], slot in [3:0] |
| byte_valid | input | 1 | One data byte is present on `byte_data` |
| byte_data | input | 8 | Data byte |
| xfer_stop | input | 1 | STOP seen on the bus |
| xfer_abort | input | 1 | Repeated START seen before STOP |
| wp | input | 1 | Write protect for the whole array, active high |
| rd_addr | input | 11 | Read address |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | Self-timed write cycle in progress |

## Verification
The main sweep tries every start slot from 0 to 15 with every transfer length from 1 to 16. Each transfer alternates between a low row and the top row, and the whole row is read back afterwards. This separates wrong slot arithmetic, carries into the row bits and writes to unloaded slots. A 20-byte transfer shows whether the last value wins at wrapped slots. A read taken mid-transfer shows whether the commit is deferred until STOP. Traffic injected during `busy`, protected transfers, data-less STOPs and aborts are each followed by a row readback and a busy-length count, which tells a discarded transfer from one that leaked into the array.

// File: rtl/pwe_pkg.sv
package pwe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_WRITE   = 2'd2
  } pwe_state_t;
endpackage

// File: rtl/pwe_page_buffer.sv
module pwe_page_buffer #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic [ADDR_W-1:0]          load_addr,
  input  logic                       take,
  input  logic [DATA_W-1:0]          take_data,
  input  logic                       wp,
  input  logic [OFF_W-1:0]           rd_slot,
  output logic [ADDR_W-OFF_W-1:0]    page_no,
  output logic [(1<<OFF_W)-1:0]      mask,
  output logic [DATA_W-1:0]          rd_byte,
  output logic                       any_valid
);
  localparam int SLOTS = 1 << OFF_W;

  logic [DATA_W-1:0] bytes_q [SLOTS];
  logic [OFF_W-1:0]  ptr_q;

  // pointer, row and valid mask
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      page_no <= '0;
      mask    <= '0;
    end else if (load) begin
      page_no <= load_addr[ADDR_W-1:OFF_W];
      ptr_q   <= load_addr[OFF_W-1:0];
      mask    <= '0;
    end else if (take) begin
      ptr_q <= ptr_q + 1'b1;          // slot only; row bits untouched
      if (!wp) mask[ptr_q] <= 1'b1;
    end
  end

  // byte storage, no reset
  always_ff @(posedge clk) begin
    if (take && !load && !wp) bytes_q[ptr_q] <= take_data;
  end

  assign rd_byte   = bytes_q[rd_slot];
  assign any_valid = |mask;

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (rst)
    (take && !load) |=> $stable(page_no)); // R2
  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (take && !load && ptr_q == OFF_W'(SLOTS-1)) |=> (ptr_q == '0)); // R2
  AST_WP_DISCARD: assert property (@(posedge clk) disable iff (rst)
    (take && !load && wp) |=> $stable(mask)); // R8
endmodule

// File: rtl/pwe_sequencer.sv
module pwe_sequencer
  import pwe_pkg::*;
#(
  parameter int OFF_W     = 4,
  parameter int WR_CYCLES = 250000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             data_valid,
  input  logic             stop,
  input  logic             abort,
  input  logic             any_valid,
  output logic             load,
  output logic             take,
  output logic             busy,
  output logic             write_phase,
  output logic [OFF_W-1:0] slot
);
  localparam int SLOTS = 1 << OFF_W;
  localparam int LIMIT = (WR_CYCLES > SLOTS) ? WR_CYCLES : SLOTS;
  localparam int CNT_W = $clog2(LIMIT + 1);

  pwe_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             last_cycle;

  assign last_cycle  = (cnt_q == CNT_W'(LIMIT - 1));
  assign load        = (state_q != ST_WRITE) && start;
  assign take        = (state_q == ST_COLLECT) && data_valid && !start && !stop && !abort;
  assign busy        = (state_q == ST_WRITE);
  assign write_phase = busy && (cnt_q < CNT_W'(SLOTS));
  assign slot        = cnt_q[OFF_W-1:0];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start) state_d = ST_COLLECT;
      ST_COLLECT: begin
        if (start)      state_d = ST_COLLECT;
        else if (abort) state_d = ST_IDLE;
        else if (stop)  state_d = any_valid ? ST_WRITE : ST_IDLE;
      end
      ST_WRITE:   if (last_cycle) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= (state_q == ST_WRITE && !last_cycle) ? cnt_q + 1'b1 : '0;
    end
  end

  AST_STOP_COMMITS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_COLLECT && stop && !start && !abort && any_valid) |=> busy); // R6
  AST_EMPTY_STOP: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_COLLECT && stop && !start && !abort && !any_valid) |=> !busy); // R9
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy && !last_cycle) |=> busy); // R7
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(cnt_q) == CNT_W'(LIMIT - 1))); // R6
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_COLLECT && abort && !start) |=> !busy); // R10
endmodule

// File: rtl/pwe_array.sv
module pwe_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/page_write_engine.sv
module page_write_engine #(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int OFF_W     = 4,
  parameter int WR_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_start,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              xfer_stop,
  input  logic              xfer_abort,
  input  logic              wp,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  localparam int SLOTS  = 1 << OFF_W;
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic              load, take, write_phase, any_valid;
  logic [OFF_W-1:0]  slot;
  logic [PAGE_W-1:0] page_no;
  logic [SLOTS-1:0]  mask;
  logic [DATA_W-1:0] slot_byte;
  logic              arr_we;

  pwe_sequencer #(.OFF_W(OFF_W), .WR_CYCLES(WR_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .start(xfer_start), .data_valid(byte_valid),
    .stop(xfer_stop), .abort(xfer_abort), .any_valid(any_valid),
    .load(load), .take(take), .busy(busy), .write_phase(write_phase), .slot(slot)
  );

  pwe_page_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_buf (
    .clk(clk), .rst(rst), .load(load), .load_addr(xfer_addr),
    .take(take), .take_data(byte_data), .wp(wp), .rd_slot(slot),
    .page_no(page_no), .mask(mask), .rd_byte(slot_byte), .any_valid(any_valid)
  );

  assign arr_we = write_phase && mask[slot];

  pwe_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .we(arr_we), .waddr({page_no, slot}), .wdata(slot_byte),
    .raddr(rd_addr), .rdata(rd_data)
  );

  AST_WRITE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> $stable(page_no)); // R2
endmodule

// File: tb/test_page_write_engine.sv
module test_page_write_engine;
  localparam int T = 24;

  logic        clk = 0;
  logic        rst = 1;
  logic        xfer_start = 0, byte_valid = 0, xfer_stop = 0, xfer_abort = 0, wp = 0;
  logic [10:0] xfer_addr = '0, rd_addr = '0;
  logic [7:0]  byte_data = '0, rd_data;
  logic        busy;

  int checks = 0, errors = 0;
  logic [7:0] model [2048];
  bit         known [2048];

  always #10 clk = ~clk;

  page_write_engine #(.ADDR_W(11), .DATA_W(8), .OFF_W(4), .WR_CYCLES(T)) i_page_write_engine (
    .clk(clk), .rst(rst), .xfer_start(xfer_start), .xfer_addr(xfer_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .xfer_stop(xfer_stop),
    .xfer_abort(xfer_abort), .wp(wp), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  function automatic logic [7:0] gen(input int a, input int k, input int seed);
    return 8'(a * 7 + k * 13 + seed * 29 + 3);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive start, n bytes, optional STOP; returns at the negedge after the last edge used
  task automatic send(input int a, input int n, input int seed, input bit do_stop);
    @(negedge clk); xfer_start = 1; xfer_addr = 11'(a);
    @(negedge clk); xfer_start = 0;
    for (int k = 0; k < n; k++) begin
      byte_valid = 1; byte_data = gen(a, k, seed);
      @(negedge clk);
    end
    byte_valid = 0;
    if (do_stop) begin
      xfer_stop = 1;
      @(negedge clk); xfer_stop = 0;
    end
  endtask

  // model of a committed transfer: slot wraps inside the row
  task automatic apply(input int a, input int n, input int seed);
    for (int k = 0; k < n; k++) begin
      int ad;
      ad = (a & 11'h7F0) | ((a + k) & 15);
      model[ad] = gen(a, k, seed);
      known[ad] = 1;
    end
  endtask

  task automatic wait_busy(input string tag);
    int c;
    c = 0;
    while (busy === 1'b1 && c < 1000) begin
      c++; @(negedge clk);
    end
    chk(tag, c, T);
  endtask

  task automatic stay_idle(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      chk(tag, {31'd0, busy}, 0);
      @(negedge clk);
    end
  endtask

  task automatic read_row(input int row, input string tag);
    for (int i = 0; i < 16; i++) begin
      int ad;
      ad = row * 16 + i;
      rd_addr = 11'(ad);
      @(negedge clk);
      if (known[ad]) chk(tag, rd_data, model[ad]);
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 busy after reset", {31'd0, busy}, 0);

    // full rows as a known background
    foreach (model[i]) known[i] = 0;
    for (int r = 0; r < 6; r++) begin
      int row;
      row = (r == 4) ? 5 : ((r == 5) ? 127 : r);
      send(row * 16, 16, 1, 1); apply(row * 16, 16, 1);
      wait_busy("R6 busy length init");
      read_row(row, "R11 init readback");
    end

    // sweep every start slot and length
    for (int s = 0; s < 16; s++) begin
      for (int n = 1; n <= 16; n++) begin
        int row, a, seed;
        row  = ((s + n) % 2 == 0) ? 1 : 127;
        a    = row * 16 + s;
        seed = s * 17 + n;
        send(a, n, seed, 1); apply(a, n, seed);
        wait_busy("R6 busy length sweep");
        read_row(row, "R2 R3 sweep row");
      end
    end

    // R4: 20 bytes wrap, last value wins
    send(3 * 16 + 5, 20, 7, 1); apply(3 * 16 + 5, 20, 7);
    wait_busy("R4 busy length");
    read_row(3, "R4 overrun row");

    // R5: no change before STOP
    send(2 * 16 + 4, 3, 9, 0);
    rd_addr = 11'(2 * 16 + 5);
    @(negedge clk);
    chk("R5 read during transfer", rd_data, model[2 * 16 + 5]);
    xfer_stop = 1;
    @(negedge clk); xfer_stop = 0;
    apply(2 * 16 + 4, 3, 9);
    wait_busy("R5 busy length");
    read_row(2, "R5 committed row");

    // R7: traffic during busy is ignored
    send(0, 16, 11, 1); apply(0, 16, 11);
    begin
      int c;
      c = 0;
      while (busy === 1'b1 && c < 1000) begin
        c++;
        xfer_start = (c == 1); xfer_addr = 11'(5 * 16);
        byte_valid = (c == 2 || c == 3); byte_data = 8'hA5;
        xfer_stop  = (c == 4);
        xfer_abort = (c == 6);
        @(negedge clk);
      end
      xfer_start = 0; byte_valid = 0; xfer_stop = 0; xfer_abort = 0;
      chk("R7 busy not extended", c, T);
    end
    stay_idle("R7 no restart after busy", 4);
    read_row(5, "R7 row untouched");
    read_row(0, "R7 own row written");

    // R8: write protect
    wp = 1;
    send(1 * 16, 8, 21, 1);
    stay_idle("R8 busy under wp", 5);
    wp = 0;
    read_row(1, "R8 row unchanged");

    // R9: STOP without data
    send(127 * 16 + 3, 0, 0, 1);
    stay_idle("R9 empty stop", 5);
    read_row(127, "R9 row unchanged");

    // R10: abort before STOP, later STOP ignored
    send(5 * 16 + 2, 4, 33, 0);
    @(negedge clk); xfer_abort = 1;
    @(negedge clk); xfer_abort = 0;
    stay_idle("R10 after abort", 3);
    xfer_stop = 1;
    @(negedge clk); xfer_stop = 0;
    stay_idle("R10 stop after abort", 4);
    read_row(5, "R10 row unchanged");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule